// File: doc/BRIEF.md
# Delegating Interrupt Priority Selector

This block decides, every clock cycle, whether a hart has a local interrupt it must take and which one. It combines the pending and enable vectors into a set of candidates. Each candidate is then placed in one of three classes according to two delegation masks: machine-handled, hypervisor-supervisor, or virtual-supervisor. Each class has its own enable rule, which depends on the current privilege level, the machine and supervisor global enables, and whether virtualization is active. Among the candidates that pass, the lowest-numbered interrupt is selected.

The result is registered. The availability flag and the cause number reflect the inputs sampled at the preceding clock edge. A one-cycle take strobe is issued only when the core says it can accept an interrupt. The core is expected to drop its ready input once it has seen the strobe. If ready stays high, the strobe is suppressed for one cycle and then repeats.

Top module: `irq_deleg_arb`

## Requirements
- R1: While reset (rstN low) is asserted, takeIrq, irqAvail and causeId are all 0.
- R2: An interrupt is a candidate only when its bit is set in both pendVec and enVec. A pending bit whose enable is 0 has no effect on the outputs.
- R3: A candidate whose mDeleg bit is 0 is in the machine class. It is allowed when the effective privilege is U or S, or when the privilege is M and mGlobalEn is 1.
- R4: The supervisor condition is true when the effective privilege is U, or when it is S and sGlobalEn is 1. It is false in M. A candidate with mDeleg=1 and hDeleg=0 is allowed when virtOn is 1 or the supervisor condition holds.
- R5: A candidate with mDeleg=1 and hDeleg=1 is allowed only when virtOn is 1 and the supervisor condition holds.
- R6: When several candidates are allowed, causeId is the index of the lowest-numbered allowed bit.
- R7: When no candidate is allowed, irqAvail is 0 and causeId is 0.
- R8: Privilege is encoded on privLvl as U=0, S=1, M=3. The value 2 behaves exactly like U.
- R9: takeIrq is 1 in the cycle after an edge at which some candidate was allowed, coreReady was 1, and takeIrq was 0. takeIrq is never 1 in two consecutive cycles.
- R10: irqAvail and causeId show the selection computed from the inputs present at the preceding rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pendVec | input | N | Pending interrupt bits |
| enVec | input | N | Per-interrupt enable bits |
| mDeleg | input | N | Machine delegation mask |
| hDeleg | input | N | Hypervisor delegation mask |
| privLvl | input | 2 | Current privilege (U=0, S=1, M=3, 2 acts as U) |
| mGlobalEn | input | 1 | Machine global interrupt enable |
| sGlobalEn | input | 1 | Supervisor global interrupt enable |
| virtOn | input | 1 | Virtualization active |
| coreReady | input | 1 | Core can accept an interrupt |
| takeIrq | output | 1 | One-cycle take strobe |
| irqAvail | output | 1 | Some interrupt is allowed |
| causeId | output | clog2(N) | Index of the selected interrupt |

## Verification
The bench targets the class boundaries. It checks an M-privilege hart with the machine enable cleared, which a design with a single global mask would wrongly let through. It checks a virtual-supervisor interrupt with virtualization off, which a design that confused the AND and OR rules would accept. It sets several allowed bits at once, so that a highest-index encoder would report the wrong cause. It drives privilege value 2, which a design decoding it as M or S would mishandle. It holds coreReady high for several cycles, so that a level-held strobe would show up as consecutive takes. A randomized sweep over every privilege and virtualization setting compares against an independent model.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;
  typedef enum logic [1:0] {
    PRIV_U   = 2'd0,
    PRIV_S   = 2'd1,
    PRIV_RSV = 2'd2,
    PRIV_M   = 2'd3
  } privLvl_t;

  typedef struct packed {
    logic fire;
  } selStrobe_t;
endpackage

// File: rtl/irq_sel_ctrl.sv
module irq_sel_ctrl (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    anyAllowed,
  input  logic                    coreReady,
  input  logic                    takeQ,
  output irq_sel_pkg::selStrobe_t strobe
);
  // Fire when something is allowed, the core accepts, and no take is in flight.
  always_comb begin
    strobe.fire = anyAllowed & coreReady & ~takeQ;
  end

  // R9
  take_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    takeQ |=> !takeQ);
endmodule

// File: rtl/irq_sel_dp.sv
module irq_sel_dp #(
  parameter int N  = 16,
  parameter int CW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [N-1:0]            pendVec,
  input  logic [N-1:0]            enVec,
  input  logic [N-1:0]            mDeleg,
  input  logic [N-1:0]            hDeleg,
  input  logic [1:0]              privLvl,
  input  logic                    mGlobalEn,
  input  logic                    sGlobalEn,
  input  logic                    virtOn,
  input  irq_sel_pkg::selStrobe_t strobe,
  output logic                    anyAllowed,
  output logic                    takeQ,
  output logic                    availQ,
  output logic [CW-1:0]           causeQ
);
  import irq_sel_pkg::*;

  privLvl_t effPriv;
  logic     mCond, sCond, hsCond, vsCond;
  logic [N-1:0] candVec, mClass, hsClass, vsClass, allowedVec, oneHot;
  logic [CW-1:0] causeNext;

  // The reserved encoding folds onto U.
  always_comb begin
    effPriv = (privLvl == PRIV_RSV) ? PRIV_U : privLvl_t'(privLvl);
    mCond   = (effPriv != PRIV_M) | mGlobalEn;
    sCond   = (effPriv == PRIV_U) | ((effPriv == PRIV_S) & sGlobalEn);
    hsCond  = virtOn | sCond;
    vsCond  = virtOn & sCond;
  end

  always_comb begin
    candVec    = pendVec & enVec;
    mClass     = candVec & ~mDeleg;
    hsClass    = candVec & mDeleg & ~hDeleg;
    vsClass    = candVec & mDeleg & hDeleg;
    allowedVec = (mClass  & {N{mCond}})
               | (hsClass & {N{hsCond}})
               | (vsClass & {N{vsCond}});
    anyAllowed = |allowedVec;
    oneHot     = allowedVec & (~allowedVec + N'(1));
  end

  for (genvar b = 0; b < CW; b++) begin : g_enc
    logic [N-1:0] hitVec;
    for (genvar i = 0; i < N; i++) begin : g_bit
      assign hitVec[i] = oneHot[i] & (((i >> b) % 2) == 1);
    end
    assign causeNext[b] = |hitVec;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      takeQ  <= 1'b0;
      availQ <= 1'b0;
      causeQ <= '0;
    end else begin
      takeQ  <= strobe.fire;
      availQ <= anyAllowed;
      causeQ <= causeNext;
    end
  end

  // Registered copy of the allowed set, kept only for the checks below.
  logic [N-1:0] allowedQ;
  always_ff @(posedge clk) begin
    if (!rstN) allowedQ <= '0;
    else       allowedQ <= allowedVec;
  end

  logic [N-1:0] belowMask;
  always_comb belowMask = (N'(1) << causeQ) - N'(1);

  // R6
  lowest_win_chk: assert property (@(posedge clk) disable iff (!rstN)
    availQ |-> (allowedQ[causeQ] && ((allowedQ & belowMask) == '0)));
  // R7
  idle_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    !availQ |-> (causeQ == '0));
  // R5
  vs_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((allowedVec & mDeleg & hDeleg) != '0) |-> (virtOn && privLvl != 2'd3));
  // R3
  m_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((allowedVec & ~mDeleg) != '0) |-> (privLvl != 2'd3 || mGlobalEn));
  // R9
  take_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    takeQ |-> availQ);
endmodule

// File: rtl/irq_deleg_arb.sv
module irq_deleg_arb #(
  parameter int N  = 16,
  parameter int CW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [N-1:0]  pendVec,
  input  logic [N-1:0]  enVec,
  input  logic [N-1:0]  mDeleg,
  input  logic [N-1:0]  hDeleg,
  input  logic [1:0]    privLvl,
  input  logic          mGlobalEn,
  input  logic          sGlobalEn,
  input  logic          virtOn,
  input  logic          coreReady,
  output logic          takeIrq,
  output logic          irqAvail,
  output logic [CW-1:0] causeId
);
  irq_sel_pkg::selStrobe_t strobe;
  logic anyAllowed;

  irq_sel_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .anyAllowed(anyAllowed),
    .coreReady (coreReady),
    .takeQ     (takeIrq),
    .strobe    (strobe)
  );

  irq_sel_dp #(.N(N), .CW(CW)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .pendVec   (pendVec),
    .enVec     (enVec),
    .mDeleg    (mDeleg),
    .hDeleg    (hDeleg),
    .privLvl   (privLvl),
    .mGlobalEn (mGlobalEn),
    .sGlobalEn (sGlobalEn),
    .virtOn    (virtOn),
    .strobe    (strobe),
    .anyAllowed(anyAllowed),
    .takeQ     (takeIrq),
    .availQ    (irqAvail),
    .causeQ    (causeId)
  );
endmodule

// File: tb/irq_deleg_arb_bench.sv
module irq_deleg_arb_bench;
  localparam int N  = 16;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [N-1:0] pendVec = '0, enVec = '0, mDeleg = '0, hDeleg = '0;
  logic [1:0] privLvl = 2'd0;
  logic mGlobalEn = 1'b0, sGlobalEn = 1'b0, virtOn = 1'b0, coreReady = 1'b0;
  logic takeIrq, irqAvail;
  logic [CW-1:0] causeId;

  int nRun = 0, nFail = 0;
  logic expTakePrev = 1'b0;

  always #5 clk = ~clk;

  irq_deleg_arb u_irq_deleg_arb (
    .clk(clk), .rstN(rstN), .pendVec(pendVec), .enVec(enVec),
    .mDeleg(mDeleg), .hDeleg(hDeleg), .privLvl(privLvl),
    .mGlobalEn(mGlobalEn), .sGlobalEn(sGlobalEn), .virtOn(virtOn),
    .coreReady(coreReady), .takeIrq(takeIrq), .irqAvail(irqAvail),
    .causeId(causeId)
  );

  // Independent model of the selection rules.
  task automatic model(output logic avail, output logic [CW-1:0] cause);
    logic mOk, sOk;
    logic [N-1:0] ok;
    int p;
    p = (privLvl == 2'd2) ? 0 : int'(privLvl);
    mOk = (p < 3) || mGlobalEn;
    sOk = (p == 0) || (p == 1 && sGlobalEn);
    avail = 1'b0;
    cause = '0;
    for (int i = 0; i < N; i++) begin
      logic c, a;
      c = pendVec[i] & enVec[i];
      if (!mDeleg[i])      a = c & mOk;
      else if (!hDeleg[i]) a = c & (virtOn | sOk);
      else                 a = c & (virtOn & sOk);
      ok[i] = a;
    end
    for (int i = N - 1; i >= 0; i--) begin
      if (ok[i]) begin
        avail = 1'b1;
        cause = CW'(i);
      end
    end
  endtask

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Let the inputs be sampled at one edge, then compare the registered outputs.
  task automatic step(string req);
    logic ea, et;
    logic [CW-1:0] ec;
    model(ea, ec);
    et = ea & coreReady & ~expTakePrev;
    @(posedge clk); #1;
    check({req, " avail"}, 8'(irqAvail), 8'(ea));
    check({req, " cause"}, 8'(causeId), 8'(ec));
    check({req, " take"}, 8'(takeIrq), 8'(et));
    expTakePrev = et;
  endtask

  task automatic setAll(logic [N-1:0] p, logic [N-1:0] e, logic [N-1:0] md,
                        logic [N-1:0] hd, logic [1:0] pr, logic mg, logic sg, logic v);
    pendVec = p; enVec = e; mDeleg = md; hDeleg = hd;
    privLvl = pr; mGlobalEn = mg; sGlobalEn = sg; virtOn = v;
  endtask

  task automatic testReset();
    @(posedge clk); #1;
    check("R1 take", 8'(takeIrq), 8'd0);
    check("R1 avail", 8'(irqAvail), 8'd0);
    check("R1 cause", 8'(causeId), 8'd0);
    rstN = 1'b1;
  endtask

  task automatic testMasking();
    // R2: pending bit 2 disabled, bit 9 enabled -> cause 9
    setAll(16'h0204, 16'h0200, '0, '0, 2'd0, 1'b0, 1'b0, 1'b0);
    step("R2 masked");
    check("R2 cause9", 8'(causeId), 8'd9);
  endtask

  task automatic testMachine();
    // R3: machine class at M with enable clear -> nothing
    setAll(16'h0080, 16'hFFFF, '0, '0, 2'd3, 1'b0, 1'b1, 1'b0);
    step("R3 M off");
    check("R3 blocked", 8'(irqAvail), 8'd0);
    mGlobalEn = 1'b1;
    step("R3 M on");
    check("R3 taken7", 8'(causeId), 8'd7);
    privLvl = 2'd1; mGlobalEn = 1'b0;
    step("R3 S lower");
  endtask

  task automatic testSuper();
    // R4: hs class at S with sGlobalEn clear, then virt on
    setAll(16'h0020, 16'hFFFF, 16'h0020, '0, 2'd1, 1'b1, 1'b0, 1'b0);
    step("R4 S off");
    check("R4 blocked", 8'(irqAvail), 8'd0);
    virtOn = 1'b1;
    step("R4 virt");
    check("R4 allowed", 8'(irqAvail), 8'd1);
    virtOn = 1'b0; privLvl = 2'd3; sGlobalEn = 1'b1;
    step("R4 M never");
  endtask

  task automatic testVirtual();
    // R5: vs class needs both virt and supervisor condition
    setAll(16'h0400, 16'hFFFF, 16'h0400, 16'h0400, 2'd0, 1'b0, 1'b0, 1'b0);
    step("R5 virt off");
    check("R5 blocked", 8'(irqAvail), 8'd0);
    virtOn = 1'b1;
    step("R5 both");
    check("R5 allowed10", 8'(causeId), 8'd10);
    privLvl = 2'd1;
    step("R5 S no sie");
  endtask

  task automatic testPriority();
    // R6: bits 3, 6, 12 allowed -> 3
    setAll(16'h1048, 16'hFFFF, '0, '0, 2'd0, 1'b0, 1'b0, 1'b0);
    step("R6 multi");
    check("R6 lowest", 8'(causeId), 8'd3);
    pendVec = 16'h8000;
    step("R6 top bit");
    check("R6 cause15", 8'(causeId), 8'd15);
    // R7: none pending
    pendVec = '0;
    step("R7 none");
    check("R7 cause0", 8'(causeId), 8'd0);
  endtask

  task automatic testPriv2();
    // R8: value 2 acts as U, so vs class allowed with virt on
    setAll(16'h0002, 16'hFFFF, 16'h0002, 16'h0002, 2'd2, 1'b0, 1'b0, 1'b1);
    step("R8 priv2");
    check("R8 as U", 8'(irqAvail), 8'd1);
  endtask

  task automatic testTake();
    // R9: ready held high -> strobe alternates, never back to back
    setAll(16'h0010, 16'hFFFF, '0, '0, 2'd0, 1'b0, 1'b0, 1'b0);
    coreReady = 1'b1;
    step("R9 t1");
    check("R9 first", 8'(takeIrq), 8'd1);
    step("R9 t2");
    check("R9 gap", 8'(takeIrq), 8'd0);
    step("R9 t3");
    coreReady = 1'b0;
    step("R9 idle");
    check("R9 not ready", 8'(takeIrq), 8'd0);
  endtask

  task automatic testLatency();
    // R10: outputs follow inputs after one edge
    setAll(16'h0100, 16'hFFFF, '0, '0, 2'd0, 1'b0, 1'b0, 1'b0);
    step("R10 a");
    pendVec = 16'h0001;
    #2;
    check("R10 held", 8'(causeId), 8'd8);
    step("R10 b");
  endtask

  task automatic testRandom();
    for (int i = 0; i < 640; i++) begin
      logic [31:0] r0, r1;
      r0 = $urandom; r1 = $urandom;
      setAll(r0[15:0], r0[31:16], r1[15:0], r1[31:16], 2'(i % 4),
             1'($urandom % 2), 1'($urandom % 2), 1'((i / 4) % 2));
      coreReady = 1'($urandom % 2);
      step("R3 R4 R5 R6 sweep");
    end
    coreReady = 1'b0;
  endtask

  initial begin
    #3000000;
    nFail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    #2;
    testReset();
    testMasking();
    testMachine();
    testSuper();
    testVirtual();
    testPriority();
    testPriv2();
    testTake();
    testLatency();
    testRandom();
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule